// File: doc/BRIEF.md
# JFIF Stream Framer

This block turns an entropy-coded scan into a complete baseline JPEG file, one byte per clock. After a start pulse it captures the picture parameters and then emits a fixed run of header segments. The run is: the start-of-image marker, a JFIF application segment, an optional EXIF application segment, the quantization tables, the frame header, the Huffman tables, an optional restart-interval segment and the scan header. It then opens a pass-through window for the already stuffed scan bytes. When the producer signals the end of the scan, it closes the file with the end-of-image marker.

Table payloads are not stored inside the block. While a table segment is being emitted, the block drives a byte address on a combinational table read port and copies the returned byte. Quantization payload sits at addresses 0 to `QT_BYTES-1`. Huffman payload follows at `QT_BYTES` onwards. The output stream has no ready signal, so a sink must accept every valid byte on the cycle it appears. On the final byte of each file, a byte count of the whole file is presented next to the last flag.

Top module: `jfif_framer`

## Requirements
- R1: After reset, `jpg_valid`, `jpg_last`, `busy` and `scan_open` are all low until a start pulse arrives.
- R2: A start pulse seen while idle produces one byte every cycle, with no gaps, from the first header byte through the final scan-header byte. The header begins with FF D8.
- R3: The JFIF segment is FF E0, length 00 10, the bytes "JFIF" and 00, version 01 01, unit 00, density 00 01 / 00 01, and thumbnail size 00 00.
- R4: When `exif_en` is high at start, a 76-byte EXIF segment (FF E1, length 74) comes right after the JFIF segment. It holds a big-endian TIFF header with offset 8 and three IFD0 entries. These are horizontal resolution (tag 011A, rational at TIFF offset 50), vertical resolution (tag 011B, rational at offset 58) and resolution unit (tag 0128, a short whose value is `res_unit`: 1 none, 2 inch, 3 cm). Each rational is the 16-bit input value over 1. When `exif_en` is low, the segment is absent.
- R5: When `rst_interval` is nonzero at start, FF DD 00 04 followed by the interval (big-endian) is placed between the Huffman segment and the scan header. When it is zero, the scan header follows the Huffman segment directly.
- R6: The frame header is FF C0 00 11 08, then the height and the width as big-endian 16-bit values, then 03. Three components follow: id 1 with sampling 0x21 and table 0, then ids 2 and 3 with sampling 0x11 and table 1.
- R7: The quantization segment is FF DB with length `QT_BYTES+2`, then the table bytes from addresses 0 onward. The Huffman segment is FF C4 with length `HT_BYTES+2`, then the bytes from address `QT_BYTES` onward. Each length counts its own two bytes but not the marker.
- R8: Scan bytes presented before `scan_open` rises are discarded. While `scan_open` is high, each byte with `scan_valid` appears unchanged one cycle later, in order. The byte sent in the same cycle as `scan_end` is included.
- R9: `scan_end` while the scan window is open is followed on the next two cycles by FF D9. `jpg_last` is high only on the D9 byte, once per file.
- R10: On the cycle `jpg_last` is high, `file_size` equals the number of bytes emitted for that file, counting the last one.
- R11: A start pulse while `busy` is high has no effect on the stream.
- R12: The scan header is FF DA 00 0C 03, followed by component/table pairs 01 00, 02 11 and 03 11, and then 00 3F 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new file (taken only when idle) |
| img_width | input | 16 | Picture width in pixels |
| img_height | input | 16 | Picture height in lines |
| exif_en | input | 1 | Insert the EXIF segment |
| x_res | input | 16 | Horizontal resolution numerator |
| y_res | input | 16 | Vertical resolution numerator |
| res_unit | input | 2 | Resolution unit code |
| rst_interval | input | 16 | Restart interval in MCUs, 0 disables |
| scan_valid | input | 1 | Scan byte present |
| scan_byte | input | 8 | Stuffed scan byte |
| scan_end | input | 1 | Scan finished |
| scan_open | output | 1 | Scan window open |
| busy | output | 1 | A file is in progress |
| tbl_addr | output | TAW | Table read address |
| tbl_data | input | 8 | Table byte at `tbl_addr`, same cycle |
| jpg_valid | output | 1 | Output byte valid |
| jpg_data | output | 8 | Output byte |
| jpg_last | output | 1 | Final byte of file |
| file_size | output | SW | Bytes in file, valid with `jpg_last` |

## Verification
A segment sequencer stuck in a wrong state or a wrong step count shows up at the ports as soon as the header stream starts. A segment is misplaced or missing, or a length field no longer matches the number of payload bytes. Either fault is visible within a few hundred bytes of the start pulse. A fault in the scan window shows up one cycle after the offending input byte: a dropped, duplicated or leaked byte, or a marker appearing before `scan_end`. A count error surfaces only on the last byte, when `file_size` is compared against the length of the collected stream.

// File: rtl/jfif_framer_pkg.sv
package jfif_framer_pkg;

  typedef enum logic [3:0] {
    SG_IDLE, SG_SOI, SG_APP0, SG_EXIF, SG_DQT, SG_SOF,
    SG_DHT, SG_DRI, SG_SOS, SG_SCAN, SG_EOI
  } seg_e;

  typedef struct packed {
    logic [15:0] width;
    logic [15:0] height;
    logic [15:0] xres;
    logic [15:0] yres;
    logic [1:0]  unit;
    logic [15:0] rst_int;
    logic        exif;
  } cfg_t;

  // total bytes of a segment, marker included
  function automatic logic [15:0] seg_len(seg_e s, logic [15:0] qt, logic [15:0] ht);
    case (s)
      SG_SOI, SG_EOI: return 16'd2;
      SG_APP0:        return 16'd18;
      SG_EXIF:        return 16'd76;
      SG_DQT:         return qt + 16'd4;
      SG_SOF:         return 16'd19;
      SG_DHT:         return ht + 16'd4;
      SG_DRI:         return 16'd6;
      SG_SOS:         return 16'd14;
      default:        return 16'd0;
    endcase
  endfunction

  function automatic seg_e next_seg(seg_e s, cfg_t c);
    case (s)
      SG_SOI:  return SG_APP0;
      SG_APP0: return c.exif ? SG_EXIF : SG_DQT;
      SG_EXIF: return SG_DQT;
      SG_DQT:  return SG_SOF;
      SG_SOF:  return SG_DHT;
      SG_DHT:  return (c.rst_int != 16'd0) ? SG_DRI : SG_SOS;
      SG_DRI:  return SG_SOS;
      SG_SOS:  return SG_SCAN;
      SG_SCAN: return SG_EOI;
      default: return SG_IDLE;
    endcase
  endfunction

  function automatic logic [7:0] app0_byte(int k);
    case (k)
      0: return 8'hFF;  1: return 8'hE0;  3: return 8'h10;
      4: return 8'h4A;  5: return 8'h46;  6: return 8'h49;  7: return 8'h46;
      9, 10, 13, 15: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // big-endian TIFF body, IFD0 at offset 8, rationals at 50 and 58
  function automatic logic [7:0] exif_byte(int k, cfg_t c);
    case (k)
      0: return 8'hFF;  1: return 8'hE1;  3: return 8'd74;
      4: return 8'h45;  5: return 8'h78;  6: return 8'h69;  7: return 8'h66;
      10, 11: return 8'h4D;
      13: return 8'h2A;  17: return 8'h08;  19: return 8'h03;
      20, 32, 44: return 8'h01;
      21: return 8'h1A;  33: return 8'h1B;  45: return 8'h28;
      23, 35: return 8'h05;
      47: return 8'h03;
      27, 39, 51, 67, 75: return 8'h01;
      31: return 8'd50;  43: return 8'd58;
      53: return {6'd0, c.unit};
      62: return c.xres[15:8];  63: return c.xres[7:0];
      70: return c.yres[15:8];  71: return c.yres[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] sof_byte(int k, cfg_t c);
    case (k)
      0: return 8'hFF;  1: return 8'hC0;  3: return 8'h11;  4: return 8'h08;
      5: return c.height[15:8];  6: return c.height[7:0];
      7: return c.width[15:8];   8: return c.width[7:0];
      9, 16: return 8'h03;
      10, 15, 18: return 8'h01;
      11: return 8'h21;  13: return 8'h02;
      14, 17: return 8'h11;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] sos_byte(int k);
    case (k)
      0: return 8'hFF;  1: return 8'hDA;  3: return 8'h0C;
      4, 9: return 8'h03;
      5: return 8'h01;  7: return 8'h02;
      8, 10: return 8'h11;
      12: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  // marker and length for the two table segments, payload from the port
  function automatic logic [7:0] tbl_seg_byte(int k, logic [7:0] mk, logic [15:0] pay,
                                              logic [7:0] tdat);
    logic [15:0] l;
    l = pay + 16'd2;
    case (k)
      0: return 8'hFF;
      1: return mk;
      2: return l[15:8];
      3: return l[7:0];
      default: return tdat;
    endcase
  endfunction

  function automatic logic [7:0] hdr_byte(seg_e s, int k, cfg_t c, logic [15:0] qt,
                                          logic [15:0] ht, logic [7:0] tdat);
    case (s)
      SG_SOI:  return (k == 0) ? 8'hFF : 8'hD8;
      SG_EOI:  return (k == 0) ? 8'hFF : 8'hD9;
      SG_APP0: return app0_byte(k);
      SG_EXIF: return exif_byte(k, c);
      SG_DQT:  return tbl_seg_byte(k, 8'hDB, qt, tdat);
      SG_SOF:  return sof_byte(k, c);
      SG_DHT:  return tbl_seg_byte(k, 8'hC4, ht, tdat);
      SG_DRI: begin
        case (k)
          0: return 8'hFF;
          1: return 8'hDD;
          3: return 8'h04;
          4: return c.rst_int[15:8];
          5: return c.rst_int[7:0];
          default: return 8'h00;
        endcase
      end
      SG_SOS:  return sos_byte(k);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/jfif_seq.sv
module jfif_seq
  import jfif_framer_pkg::*;
#(
  parameter int QT_BYTES = 130,
  parameter int HT_BYTES = 416,
  parameter int IW       = 10,
  parameter int TAW      = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  cfg_t           cfg_in,
  input  logic           scan_end,
  output seg_e           seg,
  output logic [IW-1:0]  idx,
  output cfg_t           cfg,
  output logic           at_end,
  output logic           hdr_active,
  output logic           scan_open,
  output logic           busy,
  output logic [TAW-1:0] tbl_addr
);

  logic [15:0] len;
  assign len        = seg_len(seg, 16'(QT_BYTES), 16'(HT_BYTES));
  assign at_end     = (16'(idx) == len - 16'd1);
  assign hdr_active = (seg != SG_IDLE) && (seg != SG_SCAN);
  assign scan_open  = (seg == SG_SCAN);
  assign busy       = (seg != SG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg <= SG_IDLE;
      idx <= '0;
      cfg <= '0;
    end else begin
      case (seg)
        SG_IDLE: if (start) begin
          seg <= SG_SOI;
          idx <= '0;
          cfg <= cfg_in;
        end
        SG_SCAN: if (scan_end) begin
          seg <= SG_EOI;
          idx <= '0;
        end
        default: if (at_end) begin
          seg <= next_seg(seg, cfg);
          idx <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    tbl_addr = '0;
    if (seg == SG_DQT)      tbl_addr = TAW'(idx) - TAW'(4);
    else if (seg == SG_DHT) tbl_addr = TAW'(QT_BYTES) + TAW'(idx) - TAW'(4);
  end

  logic in_soi, in_exif, in_dri, in_eoi;
  assign in_soi  = (seg == SG_SOI);
  assign in_exif = (seg == SG_EXIF);
  assign in_dri  = (seg == SG_DRI);
  assign in_eoi  = (seg == SG_EOI);

  // R2
  soi_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_soi) |-> $past(seg) == SG_IDLE);
  // R4
  exif_after_app0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_exif) |-> $past(seg) == SG_APP0);
  // R5
  dri_needs_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_dri |-> cfg.rst_int != 16'd0);
  // R9
  eoi_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_eoi) |-> $past(seg) == SG_SCAN);

endmodule

// File: rtl/jfif_out.sv
module jfif_out
  import jfif_framer_pkg::*;
#(
  parameter int QT_BYTES = 130,
  parameter int HT_BYTES = 416,
  parameter int IW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seg_e          seg,
  input  logic [IW-1:0] idx,
  input  cfg_t          cfg,
  input  logic          at_end,
  input  logic          hdr_active,
  input  logic [7:0]    tbl_data,
  input  logic          scan_valid,
  input  logic [7:0]    scan_byte,
  output logic          o_valid,
  output logic [7:0]    o_data,
  output logic          o_last
);

  logic fwd;
  assign fwd = (seg == SG_SCAN) && scan_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= 8'h00;
      o_last  <= 1'b0;
    end else begin
      o_valid <= hdr_active || fwd;
      o_data  <= hdr_active ? hdr_byte(seg, int'(idx), cfg, 16'(QT_BYTES), 16'(HT_BYTES), tbl_data)
                            : scan_byte;
      o_last  <= (seg == SG_EOI) && at_end;
    end
  end

  // R9
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_last |-> o_valid);
  // R8
  scan_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |=> o_valid && o_data == $past(scan_byte));
  // R2
  hdr_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_active |=> o_valid);

endmodule

// File: rtl/jfif_count.sv
module jfif_count #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          o_valid,
  input  logic          o_last,
  output logic [SW-1:0] size
);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (o_valid) cnt <= o_last ? '0 : cnt + 1'b1;
  end

  assign size = cnt + 1'b1;

  // R10
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_last) |=> size == SW'(1));

endmodule

// File: rtl/jfif_framer.sv
module jfif_framer
  import jfif_framer_pkg::*;
#(
  parameter int QT_BYTES = 130,
  parameter int HT_BYTES = 416,
  parameter int SW       = 24,
  localparam int MAXTBL  = (QT_BYTES > HT_BYTES) ? QT_BYTES : HT_BYTES,
  localparam int IW      = $clog2(MAXTBL + 80),
  localparam int TAW     = $clog2(QT_BYTES + HT_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [15:0]    img_width,
  input  logic [15:0]    img_height,
  input  logic           exif_en,
  input  logic [15:0]    x_res,
  input  logic [15:0]    y_res,
  input  logic [1:0]     res_unit,
  input  logic [15:0]    rst_interval,
  input  logic           scan_valid,
  input  logic [7:0]     scan_byte,
  input  logic           scan_end,
  output logic           scan_open,
  output logic           busy,
  output logic [TAW-1:0] tbl_addr,
  input  logic [7:0]     tbl_data,
  output logic           jpg_valid,
  output logic [7:0]     jpg_data,
  output logic           jpg_last,
  output logic [SW-1:0]  file_size
);

  cfg_t          cfg_in, cfg;
  seg_e          seg;
  logic [IW-1:0] idx;
  logic          at_end, hdr_active;

  assign cfg_in = '{width: img_width, height: img_height, xres: x_res, yres: y_res,
                    unit: res_unit, rst_int: rst_interval, exif: exif_en};

  jfif_seq #(.QT_BYTES(QT_BYTES), .HT_BYTES(HT_BYTES), .IW(IW), .TAW(TAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in), .scan_end(scan_end),
    .seg(seg), .idx(idx), .cfg(cfg), .at_end(at_end), .hdr_active(hdr_active),
    .scan_open(scan_open), .busy(busy), .tbl_addr(tbl_addr)
  );

  jfif_out #(.QT_BYTES(QT_BYTES), .HT_BYTES(HT_BYTES), .IW(IW)) u_out (
    .clk(clk), .rst_n(rst_n), .seg(seg), .idx(idx), .cfg(cfg), .at_end(at_end),
    .hdr_active(hdr_active), .tbl_data(tbl_data), .scan_valid(scan_valid),
    .scan_byte(scan_byte), .o_valid(jpg_valid), .o_data(jpg_data), .o_last(jpg_last)
  );

  jfif_count #(.SW(SW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .o_valid(jpg_valid), .o_last(jpg_last), .size(file_size)
  );

endmodule

// File: tb/jfif_framer_bench.sv
module jfif_framer_bench;

  localparam int QT = 130;
  localparam int HT = 416;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] img_width = 0, img_height = 0, x_res = 0, y_res = 0, rst_interval = 0;
  logic exif_en = 0;
  logic [1:0] res_unit = 0;
  logic scan_valid = 0, scan_end = 0;
  logic [7:0] scan_byte = 0;
  logic scan_open, busy, jpg_valid, jpg_last;
  logic [9:0] tbl_addr;
  logic [7:0] tbl_data, jpg_data;
  logic [23:0] file_size;

  always #5 clk = ~clk;

  assign tbl_data = 8'(int'(tbl_addr) * 3 + 17);

  jfif_framer u_jfif_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .img_width(img_width), .img_height(img_height),
    .exif_en(exif_en), .x_res(x_res), .y_res(y_res), .res_unit(res_unit),
    .rst_interval(rst_interval), .scan_valid(scan_valid), .scan_byte(scan_byte),
    .scan_end(scan_end), .scan_open(scan_open), .busy(busy), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .jpg_valid(jpg_valid), .jpg_data(jpg_data), .jpg_last(jpg_last),
    .file_size(file_size)
  );

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] got [0:2047];
  logic [7:0] exp [0:2047];
  int got_cyc [0:2047];
  int gn = 0, en = 0, n_last = 0, last_pos = -1;
  int last_size = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (jpg_valid && gn < 2048) begin
      got[gn] = jpg_data;
      got_cyc[gn] = cyc;
      if (jpg_last) begin
        n_last++;
        last_pos = gn;
        last_size = int'(file_size);
      end
      gn++;
    end
  end

  task automatic chk(string tag, int act, int want);
    total++;
    if (act != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, want);
    end
  endtask

  task automatic cmp(string tag, int from, int n);
    int bad = -1;
    for (int i = 0; i < n; i++)
      if (from + i >= gn || got[from + i] !== exp[from + i]) begin
        bad = i;
        break;
      end
    total++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: byte %0d got %02h expected %02h", tag, from + bad,
               got[from + bad], exp[from + bad]);
    end
  endtask

  function automatic logic [7:0] sbyte(int i);
    return (i == 1) ? 8'hFF : 8'(i * 37 + 5);
  endfunction

  task automatic push(logic [7:0] b);
    exp[en] = b;
    en++;
  endtask
  task automatic push16(logic [15:0] v);
    push(v[15:8]); push(v[7:0]);
  endtask
  task automatic push32(logic [31:0] v);
    push16(v[31:16]); push16(v[15:0]);
  endtask

  task automatic reset_check();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 valid after reset", int'(jpg_valid), 0);
    chk("R1 last after reset", int'(jpg_last), 0);
    chk("R1 busy/scan_open after reset", int'(busy) + int'(scan_open), 0);
  endtask

  task automatic run_file(string name, int w, int h, bit ex, int xr, int yr, int un,
                          int ri, int nscan, bit drop, bit mid_start);
    int b_app0, b_exif, b_dqt, b_sof, b_dht, b_dri, b_sos, b_scan, b_eoi, lasts0, guard;
    // expected stream
    en = 0;
    push16(16'hFFD8);
    b_app0 = en;
    push16(16'hFFE0); push16(16);
    push(8'h4A); push(8'h46); push(8'h49); push(8'h46); push(0);
    push(1); push(1); push(0); push16(1); push16(1); push16(0);
    b_exif = en;
    if (ex) begin
      push16(16'hFFE1); push16(74);
      push(8'h45); push(8'h78); push(8'h69); push(8'h66); push(0); push(0);
      push16(16'h4D4D); push16(42); push32(8); push16(3);
      push16(16'h011A); push16(5); push32(1); push32(50);
      push16(16'h011B); push16(5); push32(1); push32(58);
      push16(16'h0128); push16(3); push32(1); push16(16'(un)); push16(0);
      push32(0); push32(32'(xr)); push32(1); push32(32'(yr)); push32(1);
    end
    b_dqt = en;
    push16(16'hFFDB); push16(16'(QT + 2));
    for (int k = 0; k < QT; k++) push(8'(k * 3 + 17));
    b_sof = en;
    push16(16'hFFC0); push16(17); push(8); push16(16'(h)); push16(16'(w)); push(3);
    push(1); push(8'h21); push(0); push(2); push(8'h11); push(1); push(3); push(8'h11); push(1);
    b_dht = en;
    push16(16'hFFC4); push16(16'(HT + 2));
    for (int k = 0; k < HT; k++) push(8'((QT + k) * 3 + 17));
    b_dri = en;
    if (ri != 0) begin
      push16(16'hFFDD); push16(4); push16(16'(ri));
    end
    b_sos = en;
    push16(16'hFFDA); push16(12); push(3); push(1); push(0); push(2); push(8'h11);
    push(3); push(8'h11); push(0); push(8'h3F); push(0);
    b_scan = en;
    for (int i = 0; i < nscan; i++) push(sbyte(i));
    b_eoi = en;
    push16(16'hFFD9);

    // stimulus
    gn = 0;
    lasts0 = n_last;
    @(negedge clk);
    img_width = 16'(w); img_height = 16'(h); exif_en = ex; x_res = 16'(xr); y_res = 16'(yr);
    res_unit = 2'(un); rst_interval = 16'(ri);
    start = 1;
    @(negedge clk);
    start = 0;
    guard = 0;
    while (!scan_open && guard < 5000) begin
      scan_valid = drop;
      scan_byte = 8'hEE;
      start = mid_start && (guard == 10 || guard == 300);
      // change config mid-file as well: must not matter once a file is running
      if (mid_start && guard == 10) img_width = 16'h0BAD;
      @(negedge clk);
      guard++;
    end
    start = 0;
    for (int i = 0; i < nscan; i++) begin
      if (i % 3 == 2) begin
        scan_valid = 0; scan_end = 0;
        @(negedge clk);
      end
      scan_valid = 1;
      scan_byte = sbyte(i);
      scan_end = (i == nscan - 1);
      @(negedge clk);
    end
    scan_valid = 0; scan_end = 0;
    guard = 0;
    while (n_last == lasts0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);

    // checks
    cmp({name, " R2 SOI"}, 0, 2);
    chk({name, " R2 header contiguous"}, got_cyc[b_scan - 1] - got_cyc[0], b_scan - 1);
    cmp({name, " R3 APP0"}, b_app0, b_exif - b_app0);
    if (ex) cmp({name, " R4 EXIF"}, b_exif, b_dqt - b_exif);
    else chk({name, " R4 no EXIF, DQT follows APP0"}, int'(got[b_exif + 1]), 8'hDB);
    cmp({name, " R7 DQT"}, b_dqt, b_sof - b_dqt);
    cmp({name, " R6 SOF"}, b_sof, b_dht - b_sof);
    cmp({name, " R7 DHT"}, b_dht, b_dri - b_dht);
    if (ri != 0) cmp({name, " R5 DRI"}, b_dri, b_sos - b_dri);
    else chk({name, " R5 no DRI, SOS follows DHT"}, int'(got[b_dri + 1]), 8'hDA);
    cmp({name, " R12 SOS"}, b_sos, b_scan - b_sos);
    cmp({name, " R8 scan bytes"}, b_scan, nscan);
    cmp({name, " R9 EOI"}, b_eoi, 2);
    chk({name, " R9 one last per file"}, n_last - lasts0, 1);
    chk({name, " R9 last position"}, last_pos, en - 1);
    chk({name, " R8/R11 total bytes"}, gn, en);
    chk({name, " R10 file size"}, last_size, en);
    chk({name, " R9 idle after file"}, int'(busy), 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    reset_check();
    run_file("plain", 1280, 720, 0, 0, 0, 0, 0, 20, 1, 0);
    run_file("exif", 1920, 1080, 1, 300, 96, 3, 0, 5, 0, 0);
    run_file("restart", 16, 8, 0, 0, 0, 0, 4, 1, 1, 1);          // R11 mid-file start
    run_file("both", 640, 480, 1, 72, 72, 1, 16'h1234, 8, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule